// File: doc/BRIEF.md
# Selective-Write Vector Pack Unit

This execution unit performs a two-source lane pack. Each issue reads one 32-bit element from each of two source vectors and places it into a chosen lane of the destination. Every other lane of the destination keeps the value it already held. The current destination vector is an explicit operand, so each issue is a read-modify-write of that register. Because the untouched lanes survive, a sequence of issues can gather N scattered values into one register in N/2 operations: 4 values take 2 issues, 8 take 4 and 16 take 8. A conventional full-width shuffle would need N-1 operations for the same job.

The lane count is set by the parameter `LANES` and may be 4, 8 or 16, for 128-, 256- or 512-bit vectors. The unit accepts one operation every cycle. The result appears one cycle after the input strobe, which matches the latency of an ordinary shuffle.

Top module: `vpack_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `dst_o` is all zeros.
- R2: `imm_i[3:0]` is the index of the element read from `src_a_i`. Lane k occupies bits [32k+31:32k] of every vector.
- R3: `imm_i[7:4]` is the index of the destination lane that receives the element read from `src_a_i`.
- R4: `imm_i[11:8]` is the index of the element read from `src_b_i`.
- R5: `imm_i[15:12]` is the index of the destination lane that receives the element read from `src_b_i`.
- R6: Every destination lane named by neither destination field takes its value from `dst_i` unchanged.
- R7: When both destination fields name the same lane, that lane receives the element from `src_b_i`.
- R8: Only the low log2(`LANES`) bits of each 4-bit index field are used. With `LANES`=8, an index of 11 selects lane 3.
- R9: `valid_o` is high in exactly the cycles that follow a cycle with `valid_i` high. Operations may be issued in consecutive cycles, and each one is reflected in the output.
- R10: After a cycle with `valid_i` low, `dst_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| imm_i | input | 16 | Index fields: {dst lane B, src elem B, dst lane A, src elem A} |
| src_a_i | input | LANES*32 | First source vector |
| src_b_i | input | LANES*32 | Second source vector |
| dst_i | input | LANES*32 | Current destination vector |
| dst_o | output | LANES*32 | Updated destination vector |
| valid_o | output | 1 | Result valid |

## Verification
Two things can land in the same cycle. The two writes can target the same destination lane, and a new operation can be issued while the previous result is still being registered. Directed collision immediates, together with random immediates whose lane fields often coincide, check that lane B wins and that all other lanes come from `dst_i`. A random stream with a random strobe on every cycle exercises back-to-back issues and idle gaps. Each cycle's output is compared against a bench model: the model's result when the previous cycle was valid, and the held value otherwise.

// File: rtl/vpack_pkg.sv
`timescale 1ns/1ps
package vpack_pkg;
  localparam int unsigned ELEM_W = 32;

  // immediate layout, MSB first
  typedef struct packed {
    logic [3:0] dst_b;
    logic [3:0] src_b;
    logic [3:0] dst_a;
    logic [3:0] src_a;
  } vpack_imm_t;
endpackage

// File: rtl/vpack_elem_sel.sv
`timescale 1ns/1ps
module vpack_elem_sel
  import vpack_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ELEM_W-1:0] elem_o
);
  logic [ELEM_W-1:0] lane_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane_q[l] = vec_i[l*ELEM_W +: ELEM_W];
  end

  assign elem_o = lane_q[idx_i];
endmodule

// File: rtl/vpack_lane_merge.sv
`timescale 1ns/1ps
module vpack_lane_merge
  import vpack_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input  logic [VEC_W-1:0]  old_i,
  input  logic [ELEM_W-1:0] elem_a_i,
  input  logic [ELEM_W-1:0] elem_b_i,
  input  logic [IDX_W-1:0]  lane_a_i,
  input  logic [IDX_W-1:0]  lane_b_i,
  output logic [VEC_W-1:0]  new_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic wr_a, wr_b;
    assign wr_a = (lane_a_i == IDX_W'(l));
    assign wr_b = (lane_b_i == IDX_W'(l));
    // B has priority on collision
    assign new_o[l*ELEM_W +: ELEM_W] = wr_b ? elem_b_i :
                                       wr_a ? elem_a_i :
                                              old_i[l*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/vpack_unit.sv
`timescale 1ns/1ps
module vpack_unit
  import vpack_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [15:0]      imm_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] dst_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             valid_o
);
  vpack_imm_t        imm;
  logic [IDX_W-1:0]  sel_a, sel_b, lane_a, lane_b;
  logic [ELEM_W-1:0] elem_a, elem_b;
  logic [VEC_W-1:0]  merged;
  logic [VEC_W-1:0]  dst_q;
  logic              valid_q;
  logic              imm_unused;

  assign imm        = vpack_imm_t'(imm_i);
  // index fields wrap modulo LANES
  assign sel_a      = imm.src_a[IDX_W-1:0];
  assign lane_a     = imm.dst_a[IDX_W-1:0];
  assign sel_b      = imm.src_b[IDX_W-1:0];
  assign lane_b     = imm.dst_b[IDX_W-1:0];
  assign imm_unused = ^imm_i;

  vpack_elem_sel #(.LANES(LANES)) u_sel_a (
    .vec_i (src_a_i),
    .idx_i (sel_a),
    .elem_o(elem_a)
  );

  vpack_elem_sel #(.LANES(LANES)) u_sel_b (
    .vec_i (src_b_i),
    .idx_i (sel_b),
    .elem_o(elem_b)
  );

  vpack_lane_merge #(.LANES(LANES)) u_merge (
    .old_i   (dst_i),
    .elem_a_i(elem_a),
    .elem_b_i(elem_b),
    .lane_a_i(lane_a),
    .lane_b_i(lane_b),
    .new_o   (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) dst_q <= merged;
    end
  end

  assign dst_o   = dst_q;
  assign valid_o = valid_q;

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst_o));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R6
    keep_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && lane_a != IDX_W'(l) && lane_b != IDX_W'(l))
      |=> dst_o[l*ELEM_W +: ELEM_W] == $past(dst_i[l*ELEM_W +: ELEM_W]));
    // R5 R7
    b_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && lane_b == IDX_W'(l))
      |=> dst_o[l*ELEM_W +: ELEM_W] == $past(elem_b));
    // R3
    a_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && lane_a == IDX_W'(l) && lane_b != IDX_W'(l))
      |=> dst_o[l*ELEM_W +: ELEM_W] == $past(elem_a));
  end
endmodule

// File: tb/vpack_unit_tb.sv
`timescale 1ns/1ps
module vpack_unit_tb;
  localparam int unsigned LANES = 8;
  localparam int unsigned VEC_W = LANES * 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [15:0]      imm_i = '0;
  logic [VEC_W-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [VEC_W-1:0] dst_o;
  logic             valid_o;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;
  logic [VEC_W-1:0] exp_dst = '0;

  always #2 clk = ~clk;

  vpack_unit #(.LANES(LANES)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .imm_i  (imm_i),
    .src_a_i(src_a_i),
    .src_b_i(src_b_i),
    .dst_i  (dst_i),
    .dst_o  (dst_o),
    .valid_o(valid_o)
  );

  function automatic logic [VEC_W-1:0] rand_vec();
    logic [VEC_W-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] tag_vec(logic [7:0] tag);
    logic [VEC_W-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*32 +: 32] = {tag, 16'h0000, 8'(l)};
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] model(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
                                              logic [VEC_W-1:0] d, logic [15:0] imm);
    logic [VEC_W-1:0] r;
    int sa, da, sb, db;
    sa = int'(imm[3:0])   % LANES;
    da = int'(imm[7:4])   % LANES;
    sb = int'(imm[11:8])  % LANES;
    db = int'(imm[15:12]) % LANES;
    r = d;
    r[da*32 +: 32] = a[sa*32 +: 32];
    r[db*32 +: 32] = b[sb*32 +: 32];
    return r;
  endfunction

  task automatic check_vec(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dst_o=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: valid_o=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(string req, logic v, logic [15:0] imm,
                      logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, logic [VEC_W-1:0] d);
    @(negedge clk);
    valid_i = v; imm_i = imm; src_a_i = a; src_b_i = b; dst_i = d;
    @(posedge clk);
    #1;
    if (v) exp_dst = model(a, b, d, imm);
    check_bit(req, valid_o, v);
    check_vec(req, dst_o, exp_dst);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #3;
    // R1 reset state
    check_bit("R1", valid_o, 1'b0);
    check_vec("R1", dst_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 R3 R4 R5 R6: distinct lanes, tagged data
    step("R2 R3 R4 R5 R6", 1'b1, 16'h6_0_1_3, tag_vec(8'hAA), tag_vec(8'hBB), tag_vec(8'hDD));
    // R10: idle cycle holds, inputs changed
    step("R10", 1'b0, 16'h0_7_0_5, rand_vec(), rand_vec(), rand_vec());
    // R7 collision on lane 2
    step("R7", 1'b1, 16'h2_5_2_4, tag_vec(8'h11), tag_vec(8'h22), tag_vec(8'h33));
    // R8 indices above lane count wrap
    step("R8", 1'b1, 16'hD_B_E_9, tag_vec(8'h44), tag_vec(8'h55), tag_vec(8'h66));
    // R9 back-to-back, highest lanes
    step("R9", 1'b1, 16'h7_7_0_0, tag_vec(8'h77), tag_vec(8'h88), tag_vec(8'h99));
    step("R9", 1'b1, 16'h0_0_7_7, tag_vec(8'hA1), tag_vec(8'hB2), tag_vec(8'hC3));
    step("R9 R10", 1'b0, 16'hFFFF, rand_vec(), rand_vec(), rand_vec());

    // random stream: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      logic v;
      logic [15:0] imm;
      v = ($urandom % 4) != 0;
      imm = 16'($urandom);
      if ((i % 5) == 0) imm[15:12] = imm[7:4];
      step("R6 R7 R9 random", v, imm, rand_vec(), rand_vec(), rand_vec());
    end

    // R1 reset again mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_bit("R1", valid_o, 1'b0);
    check_vec("R1", dst_o, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule